// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the wall-clock time and the date as packed BCD digits in two 32-bit words: one for the time of day and one for the calendar. A one-cycle pulse on `tick` marks each elapsed second. On every tick the seconds field advances, and a carry ripples through minutes, hours, day-of-week, day-of-month, month, year and century within that same clock cycle. Month lengths follow the Gregorian rules, and leap years are worked out from the full four-digit year.

A host uses a simple write port and a combinational read port. To set the clock it raises request bits in the control register. Each word stops counting while its request bit is set. The next tick sets an acknowledge flag. From then on the host may write the frozen words directly. Counting resumes from the written values once the request bits are cleared. A sticky second-event flag records every tick until the host clears it. The block always runs in 24-hour form.

Top module: `bcd_cal_counter`

## Requirements
- R1: After reset the time word reads 0x00000000, the calendar word reads 0x01210020 (century 20, year 00, month 01, weekday 1, date 01), and the control and status registers read 0.
- R2: Time word layout: seconds in bits 6:0, minutes in bits 14:8, hours in bits 21:16, all BCD. Bit 22 (the afternoon flag) and every other bit always read 0. Each tick advances seconds 00..59, then minutes 00..59, then hours 00..23, with BCD digit carries (09 to 10).
- R3: The day-of-week field in calendar bits 23:21 counts 1..7. It advances when the hours wrap from 23 to 00, and goes from 7 back to 1, never to 0.
- R4: Calendar layout: day-of-month in bits 29:24, month in bits 20:16, year in bits 15:8, century in bits 6:0, all BCD. The date wraps to 01 after the last day of the month: 30 for months 04/06/09/11, 31 for the others, and 28 for month 02 or 29 in a leap year. A year is a leap year when it is divisible by 4 and is not a century year, unless the century is also divisible by 4. Month 12 wraps to 01 and carries into the year.
- R5: Year 99 wraps to 00 and carries into the century. The century wraps to 00 after parameter CENT_LAST (default 79).
- R6: While control bit 0 is 1 the time word does not change on ticks. While control bit 1 is 1 the calendar word does not change on ticks.
- R7: Status bit 0 (acknowledge) becomes 1 on the first tick seen while either request bit is 1. It is 0 whenever both request bits are 0, and writing 1 to bit 0 of the status-clear register clears it.
- R8: A write to the time word takes effect only when control bit 0 and the acknowledge flag are both 1. A write to the calendar word needs control bit 1 and the acknowledge flag. Otherwise the write is ignored. Accepted writes keep only the field bits listed in R2 and R4.
- R9: After the request bits are cleared, the next tick advances counting from the values the host wrote.
- R10: Status bit 2 (second event) becomes 1 on every tick and stays set until 1 is written to bit 2 of the status-clear register. A tick in the same cycle as the clear wins.
- R11: When only the calendar is frozen, the time keeps counting, and a 23:59:59 to 00:00:00 wrap does not change the calendar.
- R12: Register addresses: 0 control (bits 1:0, read/write), 1 time word, 2 calendar word, 3 status (read only), 4 status clear (write only, reads 0). All other addresses read 0. Writes take effect at the next clock edge. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read register address |
| rd_data | output | 32 | Read data for rd_addr |

## Verification
The bench builds the block with its defaults: AW of 3 and CENT_LAST of 0x79. Because CENT_LAST is small, the century wrap can be reached by loading year 7999 and giving a single tick. The default reset date in century 20 puts the divisible-by-400 leap case one load away. Every boundary date is set through the freeze handshake itself instead of counting through days. This checks the loading path and the carry chain together, and each ripple (second through century, plus the weekday wrap) is covered in a few hundred cycles.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;

    localparam int WORD_W = 32;

    // Fields on the main carry chain, in carry order: sec, min, hour, date, month, year, century.
    // Offsets are into the 64-bit concatenation {calendar, time}.
    localparam int NCH      = 7;
    localparam int IDX_HOUR = 2;
    localparam int IDX_DATE = 3;
    localparam int IDX_CENT = 6;
    localparam int FLD_LSB [NCH] = '{0, 8, 16, 56, 48, 40, 32};
    localparam int FLD_W   [NCH] = '{7, 7, 6, 6, 5, 8, 7};
    localparam logic [7:0] FLD_LO [NCH] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00};
    localparam logic [7:0] FLD_HI [NCH] = '{8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h99};

    localparam logic [WORD_W-1:0] TIM_MASK = 32'h003F_7F7F;
    localparam logic [WORD_W-1:0] CAL_MASK = 32'h3FFF_FF7F;

    localparam int ADR_CTRL = 0;
    localparam int ADR_TIME = 1;
    localparam int ADR_CAL  = 2;
    localparam int ADR_STAT = 3;
    localparam int ADR_SCLR = 4;

    localparam int ST_ACK = 0;
    localparam int ST_SEC = 2;

    typedef struct packed {
        logic [1:0]        req;
        logic              ack;
        logic              sev;
        logic [WORD_W-1:0] tim;
        logic [WORD_W-1:0] cal;
    } bcdc_state_t;

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'({3'b000, v[7:4]} * 7'd10 + {3'b000, v[3:0]});
    endfunction

endpackage

// File: rtl/bcdc_step.sv
module bcdc_step (
    input  logic [7:0] val,
    input  logic [7:0] lo,
    input  logic       en,
    input  logic       last,
    output logic [7:0] nxt
);
    always_comb begin
        nxt = val;
        if (en) begin
            if (last) begin
                nxt = lo;
            end else if (val[3:0] == 4'h9) begin
                nxt = {val[7:4] + 4'h1, 4'h0};
            end else begin
                nxt = val + 8'h01;
            end
        end
    end
endmodule

// File: rtl/bcdc_mlen.sv
module bcdc_mlen
    import bcdc_pkg::*;
(
    input  logic [7:0] month,
    input  logic [7:0] year,
    input  logic [7:0] century,
    output logic [7:0] last_day
);
    logic [6:0] yb_c;
    logic [6:0] cb_c;
    logic       leap_c;

    always_comb begin
        yb_c   = bcd_to_bin(year);
        cb_c   = bcd_to_bin(century);
        leap_c = ((yb_c % 7'd4) == 7'd0) && ((yb_c != 7'd0) || ((cb_c % 7'd4) == 7'd0));
        case (month)
            8'h02:                      last_day = leap_c ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcdc_chain.sv
module bcdc_chain
    import bcdc_pkg::*;
#(
    parameter logic [7:0] CENT_LAST = 8'h79
) (
    input  logic              tick,
    input  logic              time_run,
    input  logic              cal_run,
    input  logic [WORD_W-1:0] tim_q,
    input  logic [WORD_W-1:0] cal_q,
    output logic [WORD_W-1:0] tim_nx,
    output logic [WORD_W-1:0] cal_nx
);
    logic [2*WORD_W-1:0] both;
    logic [7:0]          month_len;

    assign both = {cal_q, tim_q};

    bcdc_mlen u_mlen (
        .month    ({3'b000, cal_q[20:16]}),
        .year     (cal_q[15:8]),
        .century  ({1'b0, cal_q[6:0]}),
        .last_day (month_len)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_fld
        localparam logic [7:0] MSK = 8'((1 << FLD_W[gi]) - 1);
        logic [7:0] val;
        logic [7:0] hi;
        logic [7:0] nxt;
        logic       en;
        logic       last;

        assign val  = 8'(both >> FLD_LSB[gi]) & MSK;
        assign last = (val >= hi);

        if (gi == 0) begin : g_en
            assign en = tick & time_run;
        end else if (gi == IDX_DATE) begin : g_en
            assign en = g_fld[gi-1].en & g_fld[gi-1].last & cal_run;
        end else begin : g_en
            assign en = g_fld[gi-1].en & g_fld[gi-1].last;
        end

        if (gi == IDX_DATE) begin : g_hi
            assign hi = month_len;
        end else if (gi == IDX_CENT) begin : g_hi
            assign hi = CENT_LAST;
        end else begin : g_hi
            assign hi = FLD_HI[gi];
        end

        bcdc_step u_step (
            .val  (val),
            .lo   (FLD_LO[gi]),
            .en   (en),
            .last (last),
            .nxt  (nxt)
        );
    end

    // Weekday runs beside the date, driven by the same midnight carry.
    logic [7:0] dow_val;
    logic [7:0] dow_nxt;
    logic       dow_en;

    assign dow_val = {5'b00000, cal_q[23:21]};
    assign dow_en  = g_fld[IDX_HOUR].en & g_fld[IDX_HOUR].last & cal_run;

    bcdc_step u_dow (
        .val  (dow_val),
        .lo   (8'h01),
        .en   (dow_en),
        .last (dow_val >= 8'h07),
        .nxt  (dow_nxt)
    );

    always_comb begin
        tim_nx = (tim_q & ~TIM_MASK)
               | ((32'(g_fld[0].nxt)
               | (32'(g_fld[1].nxt) << 8)
               | (32'(g_fld[2].nxt) << 16)) & TIM_MASK);
        cal_nx = (cal_q & ~CAL_MASK)
               | ((32'(g_fld[6].nxt)
               | (32'(g_fld[5].nxt) << 8)
               | (32'(g_fld[4].nxt) << 16)
               | (32'(dow_nxt) << 21)
               | (32'(g_fld[3].nxt) << 24)) & CAL_MASK);
    end
endmodule

// File: rtl/bcd_cal_counter.sv
module bcd_cal_counter
    import bcdc_pkg::*;
#(
    parameter int                AW        = 3,
    parameter logic [7:0]        CENT_LAST = 8'h79,
    parameter logic [WORD_W-1:0] CAL_INIT  = 32'h0121_0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    bcdc_state_t       s_q;
    bcdc_state_t       s_d;
    logic [WORD_W-1:0] tim_nx;
    logic [WORD_W-1:0] cal_nx;
    logic              wr_ctrl;
    logic              wr_tim;
    logic              wr_cal;
    logic              wr_sclr;
    logic              tim_we;
    logic              cal_we;

    bcdc_chain #(
        .CENT_LAST (CENT_LAST)
    ) u_chain (
        .tick     (tick),
        .time_run (~s_q.req[0]),
        .cal_run  (~s_q.req[1]),
        .tim_q    (s_q.tim),
        .cal_q    (s_q.cal),
        .tim_nx   (tim_nx),
        .cal_nx   (cal_nx)
    );

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == AW'(ADR_CTRL));
        wr_tim  = wr_en && (wr_addr == AW'(ADR_TIME));
        wr_cal  = wr_en && (wr_addr == AW'(ADR_CAL));
        wr_sclr = wr_en && (wr_addr == AW'(ADR_SCLR));
        tim_we  = wr_tim && s_q.req[0] && s_q.ack;
        cal_we  = wr_cal && s_q.req[1] && s_q.ack;

        s_d     = s_q;
        s_d.tim = tim_nx;
        s_d.cal = cal_nx;
        if (tim_we)  s_d.tim = wr_data & TIM_MASK;
        if (cal_we)  s_d.cal = wr_data & CAL_MASK;
        if (wr_ctrl) s_d.req = wr_data[1:0];

        if (wr_sclr && wr_data[ST_ACK])     s_d.ack = 1'b0;
        if (tick && (s_q.req != 2'b00))     s_d.ack = 1'b1;
        if (s_d.req == 2'b00)               s_d.ack = 1'b0;

        if (wr_sclr && wr_data[ST_SEC])     s_d.sev = 1'b0;
        if (tick)                           s_d.sev = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{req: 2'b00, ack: 1'b0, sev: 1'b0, tim: '0, cal: CAL_INIT};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            AW'(ADR_CTRL): rd_data[1:0] = s_q.req;
            AW'(ADR_TIME): rd_data      = s_q.tim;
            AW'(ADR_CAL):  rd_data      = s_q.cal;
            AW'(ADR_STAT): begin
                rd_data[ST_ACK] = s_q.ack;
                rd_data[ST_SEC] = s_q.sev;
            end
            default:       rd_data      = '0;
        endcase
    end

    a_r6_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.req[0] && !tim_we) |=> $stable(s_q.tim));

    a_r6_cal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.req[1] && !cal_we) |=> $stable(s_q.cal));

    a_r7_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ack |-> (s_q.req != 2'b00));

    a_r7_ack_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ack) |-> $past(tick));

    a_r10_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> s_q.sev);

    a_r3_weekday_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cal[23:21] != 3'd0);

    a_r2_no_afternoon_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.tim[22]);
endmodule

// File: tb/bcd_cal_counter_tb.sv
module bcd_cal_counter_tb;
    localparam int AW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    bcd_cal_counter #(.AW(AW)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    function automatic logic [7:0] bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int unbcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [31:0] tw(int h, int m, int s);
        return (32'(bcd(h)) << 16) | (32'(bcd(m)) << 8) | 32'(bcd(s));
    endfunction

    function automatic logic [31:0] cw(int c, int y, int mo, int d, int dt);
        return (32'(bcd(dt)) << 24) | (32'(d) << 21) | (32'(bcd(mo)) << 16)
             | (32'(bcd(y)) << 8) | 32'(bcd(c));
    endfunction

    // Behavioural reference model
    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_cent;
    logic [1:0] m_req;
    logic m_ack, m_sev;

    function automatic int days_in(int mo, int y, int c);
        int full;
        full = c * 100 + y;
        if (mo == 2) return (((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0)) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0;
            m_cent = 20; m_yr = 0; m_mon = 1; m_dow = 1; m_date = 1;
            m_req = 2'b00; m_ack = 1'b0; m_sev = 1'b0;
        end else begin
            logic [1:0] req_n;
            logic ack_n;
            logic sev_n;
            logic midnight;
            midnight = 1'b0;
            req_n = (wr_en && wr_addr == 0) ? wr_data[1:0] : m_req;
            ack_n = m_ack;
            sev_n = m_sev;
            if (wr_en && wr_addr == 4 && wr_data[0]) ack_n = 1'b0;
            if (tick && m_req != 2'b00) ack_n = 1'b1;
            if (req_n == 2'b00) ack_n = 1'b0;
            if (wr_en && wr_addr == 4 && wr_data[2]) sev_n = 1'b0;
            if (tick) sev_n = 1'b1;
            if (tick && !m_req[0]) begin
                m_sec++;
                if (m_sec == 60) begin
                    m_sec = 0; m_min++;
                    if (m_min == 60) begin
                        m_min = 0; m_hr++;
                        if (m_hr == 24) begin m_hr = 0; midnight = 1'b1; end
                    end
                end
            end
            if (midnight && !m_req[1]) begin
                m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                if (m_date >= days_in(m_mon, m_yr, m_cent)) begin
                    m_date = 1;
                    if (m_mon == 12) begin
                        m_mon = 1;
                        if (m_yr == 99) begin
                            m_yr = 0;
                            m_cent = (m_cent == 79) ? 0 : m_cent + 1;
                        end else m_yr++;
                    end else m_mon++;
                end else m_date++;
            end
            if (wr_en && wr_addr == 1 && m_req[0] && m_ack) begin
                m_sec = unbcd({1'b0, wr_data[6:0]});
                m_min = unbcd({1'b0, wr_data[14:8]});
                m_hr  = unbcd({2'b00, wr_data[21:16]});
            end
            if (wr_en && wr_addr == 2 && m_req[1] && m_ack) begin
                m_cent = unbcd({1'b0, wr_data[6:0]});
                m_yr   = unbcd(wr_data[15:8]);
                m_mon  = unbcd({3'b000, wr_data[20:16]});
                m_dow  = int'(wr_data[23:21]);
                m_date = unbcd({2'b00, wr_data[29:24]});
            end
            m_req = req_n; m_ack = ack_n; m_sev = sev_n;
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison against the model for the register being read
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            case (rd_addr)
                3'd0: chk("R12 control vs model", rd_data, {30'b0, m_req});
                3'd1: chk("R2 time vs model", rd_data, tw(m_hr, m_min, m_sec));
                3'd2: chk("R4 calendar vs model", rd_data, cw(m_cent, m_yr, m_mon, m_dow, m_date));
                3'd3: chk("R7 status vs model", rd_data, {29'b0, m_sev, 1'b0, m_ack});
                default: chk("R12 unmapped vs model", rd_data, 32'h0);
            endcase
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic expect_rd(int a, logic [31:0] exp, string tag);
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic load(logic [31:0] t, logic [31:0] c);
        wr(0, 32'h3);
        do_tick();
        wr(1, t);
        wr(2, c);
        wr(0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(1, 32'h0, "R1 time after reset");
        expect_rd(2, 32'h0121_0020, "R1 calendar after reset");
        expect_rd(3, 32'h0, "R1 status after reset");
        expect_rd(0, 32'h0, "R1 control after reset");

        // R2 basic counting with minute carry
        for (int i = 0; i < 61; i++) do_tick();
        expect_rd(1, tw(0, 1, 1), "R2 61 ticks");
        expect_rd(3, 32'h4, "R10 event after ticks");
        wr(4, 32'h4);
        expect_rd(3, 32'h0, "R10 event cleared");
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = AW'(4); wr_data = 32'h4;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        expect_rd(3, 32'h4, "R10 tick wins over clear");

        // R4 leap years and month lengths, R3 weekday
        load(tw(23, 59, 59), cw(20, 0, 2, 1, 28));
        do_tick();
        expect_rd(1, tw(0, 0, 0), "R2 midnight wrap");
        expect_rd(2, cw(20, 0, 2, 2, 29), "R4 year 2000 is leap");
        load(tw(23, 59, 59), cw(20, 0, 2, 2, 29));
        do_tick();
        expect_rd(2, cw(20, 0, 3, 3, 1), "R4 Feb 29 to Mar 1");
        load(tw(23, 59, 59), cw(19, 0, 2, 3, 28));
        do_tick();
        expect_rd(2, cw(19, 0, 3, 4, 1), "R4 year 1900 not leap");
        load(tw(23, 59, 59), cw(20, 24, 2, 4, 28));
        do_tick();
        expect_rd(2, cw(20, 24, 2, 5, 29), "R4 year 2024 leap");
        load(tw(23, 59, 59), cw(20, 24, 4, 2, 30));
        do_tick();
        expect_rd(2, cw(20, 24, 5, 3, 1), "R4 thirty-day month");
        load(tw(23, 59, 59), cw(20, 99, 12, 7, 31));
        do_tick();
        expect_rd(2, cw(21, 0, 1, 1, 1), "R5 R3 year and weekday wrap");
        load(tw(23, 59, 59), cw(79, 99, 12, 1, 31));
        do_tick();
        expect_rd(2, cw(0, 0, 1, 2, 1), "R5 century wrap after last");
        load(tw(9, 59, 59), cw(20, 24, 6, 6, 15));
        do_tick();
        expect_rd(1, tw(10, 0, 0), "R2 BCD hour digit carry");

        // R8 write gating, R6 freeze, R7 acknowledge, R9 resume
        wr(1, tw(5, 5, 5));
        expect_rd(1, tw(10, 0, 0), "R8 ignored without request");
        wr(0, 32'h1);
        wr(1, tw(5, 5, 5));
        expect_rd(1, tw(10, 0, 0), "R8 ignored before ack");
        expect_rd(3, 32'h4, "R7 no ack before tick");
        do_tick();
        expect_rd(3, 32'h5, "R7 ack after tick");
        expect_rd(1, tw(10, 0, 0), "R6 time frozen on tick");
        wr(2, cw(20, 1, 1, 1, 1));
        expect_rd(2, cw(20, 24, 6, 6, 15), "R8 calendar needs own request");
        wr(1, tw(5, 5, 5) | 32'hFF80_8080);
        expect_rd(1, tw(5, 5, 5), "R8 accepted write masked");
        for (int i = 0; i < 3; i++) do_tick();
        expect_rd(1, tw(5, 5, 5), "R6 frozen across ticks");
        wr(0, 32'h0);
        expect_rd(3, 32'h4, "R7 ack drops with requests");
        expect_rd(0, 32'h0, "R12 control read back");
        do_tick();
        expect_rd(1, tw(5, 5, 6), "R9 resumes from written value");

        wr(0, 32'h3);
        do_tick();
        expect_rd(3, 32'h5, "R7 ack with both requests");
        wr(4, 32'h1);
        expect_rd(3, 32'h4, "R7 ack cleared by write");
        wr(1, tw(1, 2, 3));
        expect_rd(1, tw(5, 5, 6), "R8 ignored after ack cleared");
        wr(0, 32'h0);

        // R11 calendar-only freeze drops the midnight carry
        load(tw(23, 59, 59), cw(20, 24, 6, 6, 15));
        wr(0, 32'h2);
        do_tick();
        expect_rd(1, tw(0, 0, 0), "R11 time keeps running");
        expect_rd(2, cw(20, 24, 6, 6, 15), "R11 calendar unchanged");
        wr(0, 32'h0);
        do_tick();
        expect_rd(1, tw(0, 0, 1), "R9 time after calendar release");

        // R12 write-only and unmapped addresses
        expect_rd(4, 32'h0, "R12 clear register reads zero");
        expect_rd(6, 32'h0, "R12 unmapped reads zero");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule